// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block produces one pulse-width-modulated output from a sawtooth carrier that is built by an adder, not a counter. On every clock a fixed-width accumulator adds a programmable step and wraps modulo its full range. The leftover after each overflow is kept and carried into the next carrier cycle. The carrier always spans the whole accumulator range, so the modulator gain and the duty resolution do not depend on the PWM frequency. The step sets only the slope of the carrier, and therefore the average frequency: f_pwm = step × f_clk / 2^ACC_W. Individual carrier periods may differ from each other by one clock.

The duty word may be narrower than the accumulator. It is compared for magnitude against the accumulator's most significant bits, and the output is high while the duty word is the larger of the two. New step and duty values are written into staging registers. They take effect only on the clock where the carrier overflows, so a reload can never cut a pulse short. While the active step is zero the carrier is parked, and staged values are taken on the next clock so that the carrier can start. A one-clock flag marks every carrier overflow.

Top module: `phacc_pwm_gen`

## Requirements
- R1: On every clock out of reset, the accumulator becomes (accumulator + active step) mod 2^ACC_W. On overflow the remainder is kept and the accumulator is not cleared.
- R2: `pwm_out` is 1 exactly when the active duty word, read as an unsigned number, is greater than accumulator bits [ACC_W-1 : ACC_W-DUTY_W]. An active duty of 0 gives a constant low output.
- R3: `wrap_pulse` is 1 for the one clock that follows each clock edge where the addition carried out of bit ACC_W-1, and 0 otherwise.
- R4: A step or duty strobe writes only the staging register. The active value, and with it `pwm_out` and the carrier slope, stays unchanged until the next transfer.
- R5: The staged values are copied into the active registers on a clock edge where the addition carries out. They are also copied on any edge where the active step is zero. The copy uses the staged contents from before that edge.
- R6: While `rst_n` is 0 on a clock edge, the accumulator, the active registers, the staging registers and the wrap flag are all cleared. This gives `pwm_out` = 0 and `wrap_pulse` = 0, and the carrier stays parked until a step is loaded.
- R7: With ACC_W = 8 and a step of 6, successive overflows are 43, 42, 43, 43 and 42 clocks apart. There are exactly 3 overflows in every 128 steps.
- R8: With ACC_W = 16 and an odd step of 1441, every accumulator value is visited once in 65,536 clocks. That window holds exactly 1441 overflows, and `pwm_out` is high for exactly duty × 2^(ACC_W-DUTY_W) of those clocks.
- R9: With the duty word at its all-ones value, the output is low only while the upper accumulator bits are also all ones. At a step of 1441 that is at most one clock per carrier period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_wr | input | 1 | Strobe: capture `step_in` into the staging register |
| step_in | input | ACC_W | Phase step (carrier slope) |
| duty_wr | input | 1 | Strobe: capture `duty_in` into the staging register |
| duty_in | input | DUTY_W | Duty word |
| pwm_out | output | 1 | PWM output |
| wrap_pulse | output | 1 | One-clock flag after each carrier overflow |

## Verification
The main function is tried with three kinds of step:
- An even step on an 8-bit carrier. It shows that the remainder is carried on overflow, because a carrier cleared to zero would give equal periods rather than the 43/42 pattern.
- An odd step on a 16-bit carrier, run over a full 65,536-clock window. It shows that every value is visited and that the magnitude compare uses the upper bits, since the high-time count comes out exactly right only in that case.
- A half-range step. It exposes the idle start-up path and the exact clock on which the first flag appears.

Duty words of 0, 100 and the all-ones value each bound the compare. Reloads issued in the middle of a carrier cycle show whether staging holds the old duty until the overflow.

// File: rtl/phacc_pwm_pkg.sv
// Package: shared types for the phase-accumulator PWM generator.
// Assumes: nothing beyond IEEE 1800-2017.
package phacc_pwm_pkg;

    // Why the active registers take the staged values on a given clock.
    typedef enum logic [1:0] {
        XFER_HOLD = 2'd0,   // no transfer this clock
        XFER_WRAP = 2'd1,   // carrier overflowed
        XFER_IDLE = 2'd2    // carrier parked (active step is zero)
    } xfer_reason_e;

    // Decide the transfer reason from the carry and the parked condition.
    function automatic xfer_reason_e pick_xfer(input logic carry, input logic parked);
        if (carry)       return XFER_WRAP;
        else if (parked) return XFER_IDLE;
        else             return XFER_HOLD;
    endfunction

endpackage

// File: rtl/phacc_stage_reg.sv
// Module: staging register plus active register for one programmable value.
// What it does: a write strobe loads the staging register; the active
// register copies the staging register only when xfer_en is high.
// Assumes: xfer_en is a single-cycle decision made by the parent.
module phacc_stage_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         xfer_en,
    output logic [W-1:0] active_val
);

    logic [W-1:0] staged_q;
    logic [W-1:0] active_q;

    // Capture software-side writes into the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n)     staged_q <= '0;
        else if (wr_en) staged_q <= wr_val;
    end

    // Promote the staged value into the active register on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= '0;
        else if (xfer_en) active_q <= staged_q;
    end

    assign active_val = active_q;

    // R4: the active value only moves on a transfer clock.
    assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_en && $past(rst_n)) |=> $stable(active_val));

endmodule

// File: rtl/phacc_carrier.sv
// Module: phase accumulator producing the sawtooth carrier.
// What it does: adds the active step to the accumulator on every clock,
// wrapping modulo 2^ACC_W; reports the carry combinationally and as a
// registered one-clock flag.
// Assumes: step is the active (not staged) step.
module phacc_carrier #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] phase,
    output logic             carry_now,
    output logic             wrap_flag
);

    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] phase_q;
    logic             wrap_q;
    logic [SUM_W-1:0] sum_ext;

    // Extended-width sum so the carry out is visible.
    always_comb begin
        sum_ext = {1'b0, phase_q} + {1'b0, step};
    end

    assign carry_now = sum_ext[ACC_W];

    // Advance the carrier; the remainder is kept on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= sum_ext[ACC_W-1:0];
    end

    // Register the overflow as a one-clock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) wrap_q <= 1'b0;
        else        wrap_q <= carry_now;
    end

    assign phase     = phase_q;
    assign wrap_flag = wrap_q;

    // R3: a flagged clock always follows a drop of the carrier value.
    assert_wrap_means_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wrap_flag) |-> (phase < $past(phase)));

    // R1: without a flag the carrier never moves backwards.
    assert_no_flag_no_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !wrap_flag) |-> (phase >= $past(phase)));

    // R6: reset leaves the carrier at zero with no flag.
    assert_reset_clears_R6: assert property (@(posedge clk)
        !rst_n |=> (phase == '0 && !wrap_flag));

endmodule

// File: rtl/phacc_duty_cmp.sv
// Module: magnitude comparator from duty word to PWM level.
// What it does: drives the output high while the duty word is greater
// than the carrier's upper DUTY_W bits.
// Assumes: DUTY_W <= ACC_W.
module phacc_duty_cmp #(
    parameter int ACC_W  = 16,
    parameter int DUTY_W = 8
) (
    input  logic [ACC_W-1:0]  phase,
    input  logic [DUTY_W-1:0] duty,
    output logic              level
);

    localparam int LSB = ACC_W - DUTY_W;

    logic [DUTY_W-1:0] phase_top;

    // Pick the carrier's upper bits; the slice form depends on widths.
    generate
        if (LSB == 0) begin : g_full
            always_comb phase_top = phase;
        end else begin : g_slice
            always_comb phase_top = phase[ACC_W-1:LSB];
        end
    endgenerate

    // Greater-than compare: the carrier may step past any single value.
    always_comb begin
        level = (duty > phase_top);
    end

endmodule

// File: rtl/phacc_pwm_gen.sv
// Module: phase-accumulator PWM generator (top).
// What it does: stages step and duty writes, promotes them on carrier
// overflow or while parked, runs the accumulator carrier and compares
// its upper bits against the active duty word.
// Assumes: DUTY_W <= ACC_W; reset is synchronous and active low.
module phacc_pwm_gen
    import phacc_pwm_pkg::*;
#(
    parameter int ACC_W  = 16,
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_wr,
    input  logic [ACC_W-1:0]  step_in,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              pwm_out,
    output logic              wrap_pulse
);

    localparam logic [ACC_W-1:0] STEP_ZERO = '0;

    logic [ACC_W-1:0]  step_act;
    logic [DUTY_W-1:0] duty_act;
    logic [ACC_W-1:0]  phase;
    logic              carry_now;
    logic              parked;
    logic              xfer_en;
    xfer_reason_e      xfer_why;

    // Decide whether staged values move to the active registers.
    always_comb begin
        parked   = (step_act == STEP_ZERO);
        xfer_why = pick_xfer(carry_now, parked);
        xfer_en  = (xfer_why != XFER_HOLD);
    end

    phacc_stage_reg #(.W(ACC_W)) u_step_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (step_wr),
        .wr_val     (step_in),
        .xfer_en    (xfer_en),
        .active_val (step_act)
    );

    phacc_stage_reg #(.W(DUTY_W)) u_duty_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (duty_wr),
        .wr_val     (duty_in),
        .xfer_en    (xfer_en),
        .active_val (duty_act)
    );

    phacc_carrier #(.ACC_W(ACC_W)) u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step_act),
        .phase     (phase),
        .carry_now (carry_now),
        .wrap_flag (wrap_pulse)
    );

    phacc_duty_cmp #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_cmp (
        .phase (phase),
        .duty  (duty_act),
        .level (pwm_out)
    );

    // R2: a zero active duty never lets the output rise.
    assert_zero_duty_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_act == '0) |-> !pwm_out);

    // R5: a parked carrier does not raise the overflow flag next clock.
    assert_parked_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && parked && $past(step_act) == STEP_ZERO) |-> !wrap_pulse);

    // R4: the duty seen by the comparator is stable across non-transfer clocks.
    assert_duty_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !xfer_en) |=> $stable(duty_act));

endmodule

// File: tb/sim_phacc_pwm_gen.sv
module sim_phacc_pwm_gen;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SHIFT = AW - DW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // u0: 16-bit carrier under the reference model
    logic          step_wr = 1'b0, duty_wr = 1'b0;
    logic [AW-1:0] step_in = '0;
    logic [DW-1:0] duty_in = '0;
    logic          pwm_out, wrap_pulse;

    // u1: 8-bit carrier for the period-pattern case
    logic       s1_wr = 1'b0, d1_wr = 1'b0;
    logic [7:0] s1_in = '0, d1_in = '0;
    logic       pwm1, wrap1;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    phacc_pwm_gen #(.ACC_W(AW), .DUTY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .step_wr(step_wr), .step_in(step_in),
        .duty_wr(duty_wr), .duty_in(duty_in), .pwm_out(pwm_out), .wrap_pulse(wrap_pulse));

    phacc_pwm_gen #(.ACC_W(8), .DUTY_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .step_wr(s1_wr), .step_in(s1_in),
        .duty_wr(d1_wr), .duty_in(d1_in), .pwm_out(pwm1), .wrap_pulse(wrap1));

    task automatic check(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference for u0, updated on each rising edge.
    longint m_acc = 0, m_step = 0, m_duty = 0, m_sstep = 0, m_sduty = 0;
    bit     m_wrap = 0;
    always @(posedge clk) begin
        longint sum;
        bit carry;
        if (!rst_n) begin
            m_acc = 0; m_step = 0; m_duty = 0; m_sstep = 0; m_sduty = 0; m_wrap = 0;
        end else begin
            sum   = m_acc + m_step;
            carry = (sum >= (64'd1 << AW));
            if (carry || m_step == 0) begin
                m_step = m_sstep;
                m_duty = m_sduty;
            end
            if (step_wr) m_sstep = step_in;
            if (duty_wr) m_sduty = duty_in;
            m_acc  = sum % (64'd1 << AW);
            m_wrap = carry;
        end
    end

    // Compare u0 with the reference on every clock (R2 level, R3 flag).
    always @(negedge clk) begin
        if (!done) begin
            tests++;
            if (pwm_out !== (m_duty > (m_acc >> SHIFT))) begin
                fails++;
                $display("FAIL R2 per-clock pwm_out: actual %0d expected %0d",
                         pwm_out, (m_duty > (m_acc >> SHIFT)));
            end
            tests++;
            if (wrap_pulse !== m_wrap) begin
                fails++;
                $display("FAIL R3 per-clock wrap_pulse: actual %0d expected %0d", wrap_pulse, m_wrap);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi;
        int wr;
        int lows;
        int nw;
        int wk[8];

        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6", "pwm_out in reset", pwm_out, 0);
        check("R6", "wrap_pulse in reset", wrap_pulse, 0);
        rst_n = 1'b1;

        // R7: 8-bit carrier, step 6, period pattern
        s1_in = 8'd6; d1_in = 8'd128; s1_wr = 1'b1; d1_wr = 1'b1;
        @(negedge clk);
        s1_wr = 1'b0; d1_wr = 1'b0;
        nw = 0;
        for (int k = 1; k <= 260; k++) begin
            if (k > 1) @(negedge clk);
            if (wrap1 && nw < 8) begin wk[nw] = k; nw++; end
        end
        check("R7", "overflow count in 258 clocks", nw, 6);
        check("R7", "first overflow clock", wk[0], 45);
        check("R7", "gap 1", wk[1] - wk[0], 43);
        check("R7", "gap 2", wk[2] - wk[1], 42);
        check("R7", "gap 3", wk[3] - wk[2], 43);
        check("R7", "gap 4", wk[4] - wk[3], 43);
        check("R7", "gap 5", wk[5] - wk[4], 42);
        check("R7", "3 overflows per 128 steps", wk[3] - wk[0], 128);

        // R8 and R1: odd step over the full 65536-value cycle
        step_in = 16'd1441; duty_in = 8'd100; step_wr = 1'b1; duty_wr = 1'b1;
        @(negedge clk);
        step_wr = 1'b0; duty_wr = 1'b0;
        hi = 0; wr = 0;
        for (int k = 2; k <= 65538; k++) begin
            @(negedge clk);
            if (k <= 65537 && pwm_out) hi++;
            if (k >= 3 && wrap_pulse) wr++;
        end
        check("R8", "high clocks for duty 100", hi, 100 * 256);
        check("R1", "overflows in one full cycle", wr, 1441);

        // R4: duty rewrite mid-cycle waits for the overflow
        while (!wrap_pulse) @(negedge clk);
        duty_in = 8'd0; duty_wr = 1'b1;
        @(negedge clk);
        duty_wr = 1'b0;
        check("R4", "old duty still drives pwm after write", pwm_out, 1);
        while (!wrap_pulse) @(negedge clk);
        // R2: zero duty holds the output low for a whole carrier period
        hi = 0;
        for (int k = 0; k < 50; k++) begin
            if (pwm_out) hi++;
            @(negedge clk);
        end
        check("R2", "high clocks with duty 0", hi, 0);

        // R9: full-scale duty, at most one low clock per period
        duty_in = 8'hFF; duty_wr = 1'b1;
        @(negedge clk);
        duty_wr = 1'b0;
        while (!wrap_pulse) @(negedge clk);
        @(negedge clk);
        while (!wrap_pulse) @(negedge clk);
        @(negedge clk);
        lows = 0;
        while (!wrap_pulse) begin
            if (!pwm_out) lows++;
            @(negedge clk);
        end
        check("R9", "low clocks per period <= 1", (lows <= 1), 1);

        // R6: mid-run reset clears staging, carrier stays parked
        rst_n = 1'b0;
        @(negedge clk);
        check("R6", "pwm_out after reset", pwm_out, 0);
        check("R6", "wrap_pulse after reset", wrap_pulse, 0);
        rst_n = 1'b1;
        hi = 0; wr = 0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (wrap_pulse) wr++;
        end
        check("R6", "parked carrier flags", wr, 0);
        check("R6", "parked carrier pwm", hi, 0);

        // R5: idle start-up path with a half-range step
        step_in = 16'h8000; step_wr = 1'b1;
        @(negedge clk);
        step_wr = 1'b0;
        check("R5", "flag at clock 1", wrap_pulse, 0);
        @(negedge clk);
        check("R5", "flag at clock 2", wrap_pulse, 0);
        @(negedge clk);
        check("R5", "flag at clock 3", wrap_pulse, 0);
        @(negedge clk);
        check("R5", "flag at clock 4", wrap_pulse, 1);
        @(negedge clk);
        check("R3", "flag at clock 5", wrap_pulse, 0);
        @(negedge clk);
        check("R3", "flag at clock 6", wrap_pulse, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule